// File: doc/BRIEF.md
# Sixteen-line GPIO expander register core

This block is the register side of a general-purpose I/O expander with sixteen lines, split into two ports of eight. A serial-bus target, which is not part of this block, turns bus transactions into single-cycle strobes on a small synchronous register bus. The core then answers that bus from its registers.

For every line the core holds a direction bit, an output value and an input polarity bit. It produces an output enable and a drive value for each pad. It passes the external pad levels through a synchronizer. Reads of the input ports return the synchronized levels with the selected bits inverted.

A per-port snapshot of the input levels is kept. An active-low interrupt goes low when a line that is configured as an input differs from its snapshot. The interrupt is released in one of two ways: the master reads that port's input register, which also recaptures the snapshot, or the line returns to its captured level.

An active-low reset, asynchronous on assertion, forces every register to its default. It keeps them there for as long as it is held low.

Top module: `gpx_core`

## Requirements
- R1: While `rst_n` is low, every register reads its default and writes have no effect. The defaults are: output registers 0xFF, polarity registers 0x00, configuration registers 0xFF (all lines inputs). As a result `pin_oe` is all zero and `int_n` is high.
- R2: Configuration registers sit at bus address 6 (port 0) and 7 (port 1). A bit of 1 makes its line an input and a bit of 0 makes it an output. `pin_oe` is the inverse of the configuration bits, and it changes one clock edge after the write.
- R3: Output registers sit at address 2 (port 0) and 3 (port 1). `pin_out` carries the output register bit for lines that are outputs and 0 for lines that are inputs. Port p owns line bits [8p+7:8p].
- R4: Input registers sit at address 0 (port 0) and 1 (port 1). A read returns the pad level seen through a two-flop synchronizer, XORed with the polarity register at address 4 (port 0) or 5 (port 1). A pad change shows up in the read data two clock edges after the change.
- R5: `int_n` goes low on the third clock edge after a pad change that makes an input-configured line differ from its snapshot. A change on an output-configured line never lowers `int_n`.
- R6: A read strobe at a port's input address loads that port's snapshot from the synchronized levels at that edge. This clears that port's share of the interrupt, and `int_n` rises on the following edge. A read of the other port's input address does not clear it.
- R7: If an input line returns to its snapshot level, `int_n` rises again without any read.
- R8: Writes to the input addresses 0 and 1, and writes to any address from 8 to 15, change no register. Reads of addresses 8 to 15 return 0x00. Read data is combinational on `bus_addr`.
- R9: After reset is released, the snapshot tracks the synchronized levels until the synchronizer has filled. The pad levels present during and just after reset therefore never lower `int_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, holds defaults while low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, marks a read that recaptures an input snapshot |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 16 | External pad levels, asynchronous |
| pin_oe | output | 16 | Per-line output enable |
| pin_out | output | 16 | Per-line drive value |
| int_n | output | 1 | Active-low input-change interrupt |

## Verification
Different results arrive at different times after a stimulus:

- Read data follows `bus_addr` within the same cycle.
- Register writes reach `pin_oe`, `pin_out` and the read data one edge later.
- A pad change reaches the input read data after two edges and reaches `int_n` on the third.
- A snapshot-loading read releases `int_n` one edge after the strobe's edge.

The bench drives every input just after a falling edge. Its behavioural model advances on each rising edge using the inputs that were present before that edge. All four outputs are compared with the model at the next falling edge. Directed checks then count edges explicitly, for example two edges with `int_n` still high and a low reading on the third, so that a result one cycle early or late is reported.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 2;

  // register kinds; a register's bus address is kind * ports + port
  typedef enum logic [1:0] {
    RK_INPUT    = 2'd0,
    RK_OUTPUT   = 2'd1,
    RK_POLARITY = 2'd2,
    RK_CONFIG   = 2'd3
  } reg_kind_e;

  localparam int NUM_KINDS = 4;

  function automatic int f_reg_addr(input int kind, input int port, input int nports);
    return kind * nports + port;
  endfunction

  function automatic logic [PORT_W-1:0] f_input_view(input logic [PORT_W-1:0] lvl,
                                                     input logic [PORT_W-1:0] pol);
    return lvl ^ pol;
  endfunction

  function automatic logic [PORT_W-1:0] f_pin_drive(input logic [PORT_W-1:0] outv,
                                                    input logic [PORT_W-1:0] cfg);
    return outv & ~cfg;
  endfunction

  function automatic logic f_pending(input logic [PORT_W-1:0] lvl,
                                     input logic [PORT_W-1:0] snap,
                                     input logic [PORT_W-1:0] cfg);
    return |((lvl ^ snap) & cfg);
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpx_port.sv
module gpx_port
  import gpx_pkg::*;
#(
  parameter int W   = PORT_W,
  parameter int IDX = 0,
  parameter int NP  = NUM_PORTS,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  input  logic [W-1:0]  lvl,
  input  logic          settled,
  output logic [W-1:0]  oe,
  output logic [W-1:0]  drive,
  output logic [W-1:0]  rdata,
  output logic          pend
);
  localparam logic [AW-1:0] A_IN  = AW'(f_reg_addr(int'(RK_INPUT),    IDX, NP));
  localparam logic [AW-1:0] A_OUT = AW'(f_reg_addr(int'(RK_OUTPUT),   IDX, NP));
  localparam logic [AW-1:0] A_POL = AW'(f_reg_addr(int'(RK_POLARITY), IDX, NP));
  localparam logic [AW-1:0] A_CFG = AW'(f_reg_addr(int'(RK_CONFIG),   IDX, NP));

  logic [W-1:0] out_q, pol_q, cfg_q, snap_q;

  // named decode events
  logic hit_in, hit_out, hit_pol, hit_cfg, rd_clear;
  assign hit_in   = (addr == A_IN);
  assign hit_out  = (addr == A_OUT);
  assign hit_pol  = (addr == A_POL);
  assign hit_cfg  = (addr == A_CFG);
  assign rd_clear = rd && hit_in && settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '1;
      pol_q  <= '0;
      cfg_q  <= '1;
      snap_q <= '0;
    end else begin
      if (wr && hit_out) out_q <= wdata;
      if (wr && hit_pol) pol_q <= wdata;
      if (wr && hit_cfg) cfg_q <= wdata;
      if (!settled || rd_clear) snap_q <= lvl;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_in)  rdata = f_input_view(lvl, pol_q);
    if (hit_out) rdata = out_q;
    if (hit_pol) rdata = pol_q;
    if (hit_cfg) rdata = cfg_q;
  end

  assign oe    = ~cfg_q;
  assign drive = f_pin_drive(out_q, cfg_q);
  assign pend  = settled && f_pending(lvl, snap_q, cfg_q);

  // R2: a direction write lands on the enables one edge later
  p_oe_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_cfg) |=> (oe == ~$past(wdata)));

  // R3: an output write reaches the pads only on output lines
  p_drive_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_out) |=> (drive == ($past(wdata) & oe)));

  // R8: a write to the read-only input address leaves every register alone
  p_ro_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_in) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));

  // R6: a snapshot-loading read leaves nothing pending for this port
  p_snap_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear) |=> (snap_q == $past(lvl)));
endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter int NP     = NUM_PORTS,
  parameter int W      = PORT_W,
  parameter int AW     = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [W-1:0]     bus_wdata,
  input  logic             bus_rd,
  output logic [W-1:0]     bus_rdata,
  input  logic [NP*W-1:0]  pin_in,
  output logic [NP*W-1:0]  pin_oe,
  output logic [NP*W-1:0]  pin_out,
  output logic             int_n
);
  localparam int LINES  = NP * W;
  localparam int CW     = $clog2(STAGES + 2);
  localparam int MAPPED = NUM_KINDS * NP;

  logic [LINES-1:0] lvl_sync;
  logic [CW-1:0]    settle_cnt;
  logic             settled;
  logic [NP-1:0]    pend_vec;
  logic [W-1:0]     port_rdata [NP];
  logic             pend_any;
  logic             int_q;

  gpx_sync #(.W(LINES), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (lvl_sync)
  );

  // snapshot follows the synchronizer until it has filled after reset
  assign settled = (settle_cnt > CW'(STAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        settle_cnt <= '0;
    else if (!settled) settle_cnt <= settle_cnt + 1'b1;
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    gpx_port #(.W(W), .IDX(p), .NP(NP), .AW(AW)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .wr     (bus_wr),
      .wdata  (bus_wdata),
      .rd     (bus_rd),
      .lvl    (lvl_sync[p*W +: W]),
      .settled(settled),
      .oe     (pin_oe[p*W +: W]),
      .drive  (pin_out[p*W +: W]),
      .rdata  (port_rdata[p]),
      .pend   (pend_vec[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NP; p++) bus_rdata = bus_rdata | port_rdata[p];
  end

  assign pend_any = |pend_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= 1'b1;
    else        int_q <= ~pend_any;
  end

  assign int_n = int_q;

  // R5: a low interrupt always has a pending input difference behind it
  p_int_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n) |-> $past(pend_any));

  // R7: once nothing is pending the interrupt is released on the next edge
  p_int_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && !pend_any) |=> int_n);

  // R9: no interrupt while the synchronizer is still filling
  p_quiet_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!settled) |=> int_n);

  // R8: unmapped reads return zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= AW'(MAPPED)) |-> (bus_rdata == '0));
endmodule

// File: tb/gpx_core_bench.sv
module gpx_core_bench;
  localparam int STAGES = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0;
  logic [15:0] pins = 16'hA5C3;
  logic [7:0]  rdata;
  logic [15:0] oe, pout;
  logic        int_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_out, m_pol, m_cfg, m_snap;
  logic        m_int;
  int          m_cnt;
  logic [15:0] hist [$];

  always #5 clk = ~clk;

  gpx_core u_gpx_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .pin_in(pins), .pin_oe(oe), .pin_out(pout),
    .int_n(int_n)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_out = 16'hFFFF; m_pol = '0; m_cfg = 16'hFFFF; m_snap = '0;
    m_int = 1'b1; m_cnt = 0;
    hist.delete(); hist.push_back('0); hist.push_back('0);
  endtask

  task automatic model_edge();
    logic [15:0] s2;
    bit settled, pend;
    if (!rst_n) begin
      model_reset();
      return;
    end
    s2 = hist[0];
    settled = (m_cnt > STAGES);
    pend = settled && (((s2 ^ m_snap) & m_cfg) != 0);
    if (wr) begin
      case (addr)
        4'd2: m_out[7:0]  = wdata;
        4'd3: m_out[15:8] = wdata;
        4'd4: m_pol[7:0]  = wdata;
        4'd5: m_pol[15:8] = wdata;
        4'd6: m_cfg[7:0]  = wdata;
        4'd7: m_cfg[15:8] = wdata;
        default: ;
      endcase
    end
    if (!settled) m_snap = s2;
    else if (rd && addr == 4'd0) m_snap[7:0]  = s2[7:0];
    else if (rd && addr == 4'd1) m_snap[15:8] = s2[15:8];
    if (m_cnt <= STAGES) m_cnt++;
    void'(hist.pop_front());
    hist.push_back(pins);
    m_int = !pend;
  endtask

  function automatic logic [7:0] model_rdata();
    logic [15:0] view;
    view = hist[0] ^ m_pol;
    case (addr)
      4'd0: return view[7:0];
      4'd1: return view[15:8];
      4'd2: return m_out[7:0];
      4'd3: return m_out[15:8];
      4'd4: return m_pol[7:0];
      4'd5: return m_pol[15:8];
      4'd6: return m_cfg[7:0];
      4'd7: return m_cfg[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // one clock: model advances on the rising edge, outputs compared on the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R2 pin_oe", oe, ~m_cfg);
    check("R3 pin_out", pout, m_out & ~m_cfg);
    check("R5 int_n", {15'd0, int_n}, {15'd0, m_int});
    check("R4 bus_rdata", {8'd0, rdata}, {8'd0, model_rdata()});
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    step();
    wr = 1'b0;
  endtask

  task automatic bus_look(input logic [3:0] a);
    addr = a; wr = 1'b0; rd = 1'b0;
    step();
  endtask

  initial begin
    logic [15:0] lfsr;
    model_reset();
    @(negedge clk);
    // R1: writes during reset are ignored, defaults held
    addr = 4'd6; wdata = 8'h00; wr = 1'b1;
    steps(2);
    wr = 1'b0;
    check("R1 oe in reset", oe, 16'h0000);
    bus_look(4'd2);
    check("R1 out default", {8'd0, rdata}, 16'h00FF);
    check("R1 int_n in reset", {15'd0, int_n}, 16'd1);

    // R9: release with nonzero pads, no spurious interrupt
    rst_n = 1'b1;
    addr = 4'd0;
    steps(6);
    check("R9 quiet after reset", {15'd0, int_n}, 16'd1);
    check("R4 port0 read", {8'd0, rdata}, 16'h00C3);

    // R2 / R3: low nibble inputs, high nibble outputs on port 0
    bus_write(4'd6, 8'h0F);
    bus_write(4'd2, 8'h5A);
    bus_look(4'd0);
    check("R2 oe after cfg", oe, 16'h00F0);
    check("R3 drive after out", pout, 16'h0050);

    // R4: polarity on port 1
    bus_write(4'd5, 8'hFF);
    bus_look(4'd1);
    check("R4 inverted read", {8'd0, rdata}, 16'h005A);

    // R5: input line 9 changes, interrupt on the third edge
    addr = 4'd3;
    pins = pins ^ 16'h0200;
    steps(2);
    check("R5 not yet", {15'd0, int_n}, 16'd1);
    step();
    check("R5 asserted", {15'd0, int_n}, 16'd0);

    // R6: reading the other port does not clear; the right port does
    addr = 4'd0; rd = 1'b1; step(); rd = 1'b0; steps(2);
    check("R6 other port keeps", {15'd0, int_n}, 16'd0);
    addr = 4'd1; rd = 1'b1; step(); rd = 1'b0;
    step();
    check("R6 cleared by read", {15'd0, int_n}, 16'd1);

    // R7: input line 2 toggles and returns
    pins = pins ^ 16'h0004;
    steps(3);
    check("R7 asserted", {15'd0, int_n}, 16'd0);
    pins = pins ^ 16'h0004;
    steps(3);
    check("R7 released on return", {15'd0, int_n}, 16'd1);

    // R5: output line 6 toggling never interrupts
    pins = pins ^ 16'h0040;
    steps(4);
    check("R5 output line quiet", {15'd0, int_n}, 16'd1);

    // R8: read-only and unmapped writes ignored, unmapped read zero
    bus_write(4'd0, 8'h00);
    bus_write(4'd1, 8'h00);
    bus_write(4'd9, 8'h77);
    bus_look(4'd2);
    check("R8 out unchanged", {8'd0, rdata}, 16'h005A);
    bus_look(4'd6);
    check("R8 cfg unchanged", {8'd0, rdata}, 16'h000F);
    bus_look(4'd5);
    check("R8 pol unchanged", {8'd0, rdata}, 16'h00FF);
    bus_look(4'd9);
    check("R8 unmapped read", {8'd0, rdata}, 16'h0000);

    // R1: reset in mid-run restores defaults
    rst_n = 1'b0;
    steps(2);
    rst_n = 1'b1;
    bus_look(4'd6);
    check("R1 cfg default", {8'd0, rdata}, 16'h00FF);
    bus_look(4'd5);
    check("R1 pol default", {8'd0, rdata}, 16'h0000);
    check("R1 oe default", oe, 16'h0000);

    // mixed traffic against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      addr  = lfsr[3:0];
      wr    = lfsr[4] & lfsr[5];
      rd    = lfsr[6];
      wdata = lfsr[15:8];
      if (lfsr[7] && lfsr[9]) pins = pins ^ (16'd1 << lfsr[13:10]);
      rst_n = (i % 200 != 199);
      step();
    end
    rst_n = 1'b1; wr = 1'b0; rd = 1'b0;
    steps(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule